// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers every interrupt request a small CPU can see and turns them into one vector address. The requests are a reset request, one non-maskable request and five maskable requests: coprocessor completion, converter completion, timer, an 8-bit pin group and an external pin. It keeps a pending flag for each source. From the flags it picks the most urgent one the global mask allows and presents the low address of that source's two-byte vector slot. The CPU fetches that slot and the next address after it.

The 8-bit pin group is used as a set of interrupt pins. Each pin passes through a two-flop synchronizer and a previous-value compare, so that a high-to-low transition is caught. Each pin also has a per-pin enable register in which a 0 enables the pin. The external pin works in the same way, but only while its function-select input chooses the interrupt role.

When the CPU pulses `ack`, the flag of the source currently presented is cleared. The selection is then made again. Both outputs are registered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `vec_addr` is 16'hFFFC and `irq_pend` is 1. This holds until that reset entry is acknowledged, whatever other requests are pending.
- R2: When several sources are pending, the one presented is chosen in this order, most urgent first: reset, non-maskable, coprocessor done, converter done, timer, pin group, external pin.
- R3: The vector addresses are coprocessor done 16'hFFF0, converter done 16'hFFF2, timer 16'hFFF6, pin group 16'hFFF8, non-maskable 16'hFFFA, reset 16'hFFFC and external pin 16'hFFFE. No source uses 16'hFFF4.
- R4: While `irq_mask` is 1, the five maskable sources are not presented, and if nothing else is pending `irq_pend` is 0. Their flags stay latched and are presented once `irq_mask` returns to 0. Reset and the non-maskable source ignore `irq_mask`.
- R5: The non-maskable source is latched on a rising edge of `nmi_req`. Holding the input high raises only one request.
- R6: An `ack` pulse while `irq_pend` is 1 clears only the flag of the source presented. The next selection appears after the same clock edge. An `ack` while `irq_pend` is 0 has no effect. A new request from the acknowledged source in the same cycle stays pending.
- R7: A falling edge on an enabled pin of `pa_pins` sets the pin-group flag. It is seen at the outputs after the third rising clock edge that samples the new pin level. Rising edges set nothing.
- R8: The pin enables are active low: enable bit i equal to 0 enables pin i. The register loads `en_wdata` when `en_we` is 1, and every bit resets to 1, so all pins start disabled.
- R9: A falling edge on `ext_pin` sets the external flag only while `ext_sel` is 1, with the same latency as R7. With `ext_sel` at 0 the pin is an ordinary input and raises nothing.
- R10: A one-cycle pulse on `cop_req`, `adc_req` or `tmr_req` that is high before a clock edge shows at the outputs after that edge. While nothing can be presented, `vec_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also posts the reset entry |
| nmi_req | input | 1 | Non-maskable request, rising-edge latched |
| cop_req | input | 1 | Coprocessor-done request pulse |
| adc_req | input | 1 | Converter-done request pulse |
| tmr_req | input | 1 | Timer request pulse |
| pa_pins | input | PA_W | Pin-group levels, falling edge requests |
| ext_pin | input | 1 | External interrupt pin level |
| ext_sel | input | 1 | 1 selects the interrupt role of `ext_pin` |
| en_we | input | 1 | Write strobe for the pin enable register |
| en_wdata | input | PA_W | Active-low pin enables to load |
| irq_mask | input | 1 | Global mask for maskable sources |
| ack | input | 1 | CPU acknowledge of the presented vector |
| vec_addr | output | 16 | Low address of the selected vector slot |
| irq_pend | output | 1 | A request is presented |

## Verification
Request pulses, the rising edge of `nmi_req`, acknowledges and mask changes all take effect at the outputs after the one clock edge that samples them. Pin-group and external-pin falls take effect after three edges, because of the two synchronizer stages and the previous-value stage. The reference model in the bench delays its copy of the pin levels by the same number of edges and then works out pending flags, mask and selection behaviourally. It is compared with `vec_addr` and `irq_pend` at every falling clock edge. The directed steps drive inputs on a falling edge and read the result one falling edge later, or three falling edges later for the pin paths.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC  = 7;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFF0;

  // Source index doubles as priority: lower index wins.
  localparam int S_RST = 0;
  localparam int S_NMI = 1;
  localparam int S_COP = 2;
  localparam int S_ADC = 3;
  localparam int S_TMR = 4;
  localparam int S_PA  = 5;
  localparam int S_EXT = 6;

  // Sources that the global mask can hold off.
  localparam logic [NSRC-1:0] MASKABLE = 7'b111_1100;

  // Slot number (two bytes each) above VEC_BASE for a source index.
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [2:0] slot;
    case (idx)
      IDX_W'(S_COP): slot = 3'd0;
      IDX_W'(S_ADC): slot = 3'd1;
      IDX_W'(S_TMR): slot = 3'd3;
      IDX_W'(S_PA):  slot = 3'd4;
      IDX_W'(S_NMI): slot = 3'd5;
      IDX_W'(S_RST): slot = 3'd6;
      default:       slot = 3'd7;
    endcase
    return VEC_BASE + VEC_W'({slot, 1'b0});
  endfunction
endpackage

// File: rtl/irqv_fall_sync.sv
module irqv_fall_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  // Idle level is high (pulled-up pins), so reset to ones: no false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = prev_q & ~s2_q;
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick
  import irqv_pkg::*;
#(
  parameter int N = NSRC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int PA_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_req,
  input  logic             cop_req,
  input  logic             adc_req,
  input  logic             tmr_req,
  input  logic [PA_W-1:0]  pa_pins,
  input  logic             ext_pin,
  input  logic             ext_sel,
  input  logic             en_we,
  input  logic [PA_W-1:0]  en_wdata,
  input  logic             irq_mask,
  input  logic             ack,
  output logic [VEC_W-1:0] vec_addr,
  output logic             irq_pend
);
  localparam logic [VEC_W-1:0] RST_VEC = 16'hFFFC;

  logic [NSRC-1:0]  pend_q, pend_d, set_v, clr_v, elig;
  logic [PA_W-1:0]  en_n_q, pa_fall;
  logic [0:0]       ext_fall;
  logic             nmi_prev_q;
  logic [IDX_W-1:0] src_q, pick_idx;
  logic             pick_valid;
  logic [VEC_W-1:0] vec_q;
  logic             out_q;

  irqv_fall_sync #(.W(PA_W)) u_pa_sync (
    .clk(clk), .rst(rst), .din(pa_pins), .fall(pa_fall)
  );

  irqv_fall_sync #(.W(1)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_pin), .fall(ext_fall)
  );

  always_comb begin
    set_v        = '0;
    set_v[S_NMI] = nmi_req & ~nmi_prev_q;
    set_v[S_COP] = cop_req;
    set_v[S_ADC] = adc_req;
    set_v[S_TMR] = tmr_req;
    set_v[S_PA]  = |(pa_fall & ~en_n_q);
    set_v[S_EXT] = ext_fall[0] & ext_sel;
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_clr
      assign clr_v[g] = ack & out_q & (src_q == IDX_W'(g));
    end
  endgenerate

  // Set wins over clear so a fresh request is never lost.
  assign pend_d = (pend_q & ~clr_v) | set_v;
  assign elig   = pend_d & ~({NSRC{irq_mask}} & MASKABLE);

  irqv_prio_pick #(.N(NSRC)) u_pick (
    .elig(elig), .valid(pick_valid), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= NSRC'(1) << S_RST;
      en_n_q     <= '1;
      nmi_prev_q <= 1'b0;
      vec_q      <= RST_VEC;
      src_q      <= IDX_W'(S_RST);
      out_q      <= 1'b1;
    end else begin
      pend_q     <= pend_d;
      nmi_prev_q <= nmi_req;
      if (en_we) en_n_q <= en_wdata;
      out_q      <= pick_valid;
      if (pick_valid) begin
        vec_q <= vec_of(pick_idx);
        src_q <= pick_idx;
      end
    end
  end

  assign vec_addr = vec_q;
  assign irq_pend = out_q;

  // R1: reset posts the reset vector on the following cycle.
  a_r1_reset_vector: assert property (@(posedge clk)
    rst |=> (vec_addr == RST_VEC && irq_pend));

  // R1: a pending reset entry outranks everything.
  a_r1_reset_first: assert property (@(posedge clk) disable iff (rst)
    pend_q[S_RST] |-> (vec_addr == RST_VEC && irq_pend));

  // R2: the non-maskable entry beats every maskable one.
  a_r2_nmi_over_maskable: assert property (@(posedge clk) disable iff (rst)
    (pend_q[S_NMI] && !pend_q[S_RST]) |-> (vec_addr == 16'hFFFA && irq_pend));

  // R4: under the global mask only reset or non-maskable vectors appear.
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (irq_pend && $past(irq_mask)) |-> (vec_addr == RST_VEC || vec_addr == 16'hFFFA));

  // R6: acknowledging the reset entry clears it.
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_pend && src_q == IDX_W'(S_RST)) |=> !pend_q[S_RST]);

  // R8: all pin enables come out of reset disabled.
  a_r8_enable_reset: assert property (@(posedge clk)
    rst |=> (en_n_q == '1));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W       = 8;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nmi_req = 0, cop_req = 0, adc_req = 0, tmr_req = 0;
  logic [PA_W-1:0] pa_pins = '1;
  logic ext_pin = 1'b1, ext_sel = 1'b0;
  logic en_we = 1'b0;
  logic [PA_W-1:0] en_wdata = '1;
  logic irq_mask = 1'b0, ack = 1'b0;
  logic [15:0] vec_addr;
  logic irq_pend;

  int tests = 0, fails = 0, cycles = 0;
  string phase = "R1";
  bit model_live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(.PA_W(PA_W)) u_dut (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .cop_req(cop_req),
    .adc_req(adc_req), .tmr_req(tmr_req), .pa_pins(pa_pins),
    .ext_pin(ext_pin), .ext_sel(ext_sel), .en_we(en_we),
    .en_wdata(en_wdata), .irq_mask(irq_mask), .ack(ack),
    .vec_addr(vec_addr), .irq_pend(irq_pend)
  );

  // Vector table from R3, by source rank from R2 (0 = most urgent).
  function automatic logic [15:0] addr_of(int rank);
    case (rank)
      0: return 16'hFFFC;
      1: return 16'hFFFA;
      2: return 16'hFFF0;
      3: return 16'hFFF2;
      4: return 16'hFFF6;
      5: return 16'hFFF8;
      default: return 16'hFFFE;
    endcase
  endfunction

  // Behavioural reference model.
  bit   pend[7];
  logic [15:0] m_vec;
  bit   m_out;
  int   m_src;
  logic [PA_W-1:0] pa_hist[$];
  bit   ext_hist[$];
  logic [PA_W-1:0] m_en;
  bit   m_nmi_last;

  always @(posedge clk) begin
    if (rst) begin
      foreach (pend[i]) pend[i] = 0;
      pend[0] = 1;
      m_en = '1; m_nmi_last = 0;
      pa_hist = '{'1, '1, '1};
      ext_hist = '{1, 1, 1};
      m_vec = 16'hFFFC; m_out = 1; m_src = 0;
      model_live = 1;
    end else begin
      bit nw[7];
      bit found;
      // pa_hist[0] oldest: levels two and one edges before the newest sample.
      foreach (nw[i]) nw[i] = 0;
      nw[1] = nmi_req && !m_nmi_last;
      nw[2] = cop_req; nw[3] = adc_req; nw[4] = tmr_req;
      nw[5] = |((pa_hist[0] & ~pa_hist[1]) & ~m_en);
      nw[6] = ext_hist[0] && !ext_hist[1] && ext_sel;
      if (ack && m_out) pend[m_src] = 0;
      foreach (pend[i]) pend[i] = pend[i] | nw[i];
      void'(pa_hist.pop_front()); pa_hist.push_back(pa_pins);
      void'(ext_hist.pop_front()); ext_hist.push_back(ext_pin);
      m_nmi_last = nmi_req;
      if (en_we) m_en = en_wdata;
      found = 0;
      for (int i = 0; i < 7; i++) begin
        if (!found && pend[i] && (i < 2 || !irq_mask)) begin
          found = 1; m_src = i; m_vec = addr_of(i);
        end
      end
      m_out = found;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (model_live) begin
      tests++;
      if (vec_addr !== m_vec || irq_pend !== m_out) begin
        fails++;
        $display("FAIL %s model compare: vec=%h pend=%0b expected vec=%h pend=%0b",
                 phase, vec_addr, irq_pend, m_vec, m_out);
      end
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1; tick(1); ack = 0;
  endtask

  initial begin
    tick(3);
    chk("R1 reset vector", vec_addr, 16'hFFFC);
    chk("R1 reset pending", 16'(irq_pend), 16'h1);
    rst = 0; tick(1);
    // R1: other requests do not displace the reset entry
    nmi_req = 1; cop_req = 1; tick(1); cop_req = 0;
    chk("R1 reset holds", vec_addr, 16'hFFFC);
    phase = "R2";
    do_ack(); chk("R2 nmi next", vec_addr, 16'hFFFA);
    do_ack(); chk("R2 cop next", vec_addr, 16'hFFF0);
    phase = "R5";
    tick(3); do_ack();  // R5: held nmi_req gives no second request
    chk("R5 no retrigger", 16'(irq_pend), 16'h0);
    chk("R10 vector held", vec_addr, 16'hFFF0);
    nmi_req = 0;
    phase = "R3";
    tmr_req = 1; adc_req = 1; tick(1); tmr_req = 0; adc_req = 0;
    chk("R3 adc vector", vec_addr, 16'hFFF2);
    do_ack(); chk("R3 timer vector", vec_addr, 16'hFFF6);
    do_ack(); chk("R6 cleared all", 16'(irq_pend), 16'h0);
    phase = "R6";
    do_ack(); chk("R6 idle ack no effect", vec_addr, 16'hFFF6);
    // R6: acknowledge and fresh request of same source together
    cop_req = 1; tick(1); cop_req = 0;
    cop_req = 1; ack = 1; tick(1); cop_req = 0; ack = 0;
    chk("R6 set wins", vec_addr, 16'hFFF0);
    do_ack();
    phase = "R4";
    irq_mask = 1; tmr_req = 1; tick(1); tmr_req = 0;
    chk("R4 masked idle", 16'(irq_pend), 16'h0);
    nmi_req = 1; tick(1); nmi_req = 0;
    chk("R4 nmi passes mask", vec_addr, 16'hFFFA);
    do_ack(); irq_mask = 0; tick(1);
    chk("R4 latched timer", vec_addr, 16'hFFF6);
    do_ack();
    phase = "R7";
    pa_pins[3] = 0; tick(4); pa_pins[3] = 1; tick(4);
    chk("R8 disabled pin", 16'(irq_pend), 16'h0);
    en_we = 1; en_wdata = ~8'h08; tick(1); en_we = 0;
    pa_pins[3] = 0; tick(2);
    chk("R7 not yet", 16'(irq_pend), 16'h0);
    tick(1);
    chk("R7 pin fall", vec_addr, 16'hFFF8);
    do_ack(); pa_pins[3] = 1; tick(4);
    chk("R7 rise ignored", 16'(irq_pend), 16'h0);
    phase = "R9";
    ext_pin = 0; tick(4); ext_pin = 1; tick(4);
    chk("R9 pin mode", 16'(irq_pend), 16'h0);
    ext_sel = 1; ext_pin = 0; tick(3);
    chk("R9 ext fall", vec_addr, 16'hFFFE);
    do_ack(); ext_pin = 1; tick(4);
    phase = "R2/R6 random";
    for (int k = 0; k < 4000; k++) begin
      nmi_req  = ($urandom_range(0, 15) == 0);
      cop_req  = ($urandom_range(0, 9) == 0);
      adc_req  = ($urandom_range(0, 9) == 0);
      tmr_req  = ($urandom_range(0, 9) == 0);
      pa_pins  = 8'($urandom);
      ext_pin  = 1'($urandom);
      ext_sel  = ($urandom_range(0, 3) != 0);
      en_we    = ($urandom_range(0, 19) == 0);
      en_wdata = 8'($urandom);
      irq_mask = ($urandom_range(0, 4) == 0);
      ack      = ($urandom_range(0, 2) == 0);
      rst      = ($urandom_range(0, 499) == 0);
      tick(1);
    end
    rst = 0; ack = 0;
    tick(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule